// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Front End

This block is the synchronous digital front end of a 12-bit digital-to-analog converter that is fed from an 8-bit processor bus. A processor writes the code as two byte transfers, in either order, into an input holding register. A second register, the converter register, drives the code presented to the analog section. It updates either in the same write that delivers a byte or later through a separate transfer command, so that several converters on one bus can change together.

All bus strobes are active low and are brought into the system clock domain through a synchronizer. Each register action happens once for each falling edge of the write strobe. Two mode pins pick the packing of the 12-bit code into the two bytes, left or right justified. They can also force the output code to all zeros or all ones without disturbing the stored words.

Top module: `dacif_top`

## Requirements
- R1: After reset the input register, the converter register and the output code are all zero.
- R2: A write with the low-byte select low, the high-byte select high and load high changes only the low-byte field of the input register. The converter register is left unchanged.
- R3: A write with the high-byte select low, the low-byte select high and load high changes only the high-byte field of the input register. The converter register is left unchanged.
- R4: A byte write with load low also copies the input word into the converter register. The copied word already holds the byte delivered in that same write.
- R5: A write with both chip selects high and load low copies the input register into the converter register and takes no bus data.
- R6: While the write strobe stays high, no register changes, whatever the selects, load or bus data do.
- R7: A write with both chip selects low changes no register.
- R8: Each falling edge of write causes at most one action. Its effect is visible on the register outputs no more than 3 clock cycles after the edge on which write is first sampled low. Keeping write low does not repeat the action, and strobe or data changes made while it is low do nothing.
- R9: With control low at the write, packing is left justified. The high byte supplies code bits 11..4, and bits 7..4 of the low byte supply code bits 3..0. Low-byte bits 3..0 are ignored.
- R10: With control high at the write, packing is right justified. Bits 3..0 of the high byte supply code bits 11..8, and the low byte supplies bits 7..0. High-byte bits 7..4 are ignored.
- R11: With override low, the output code is 0x000 when control is 0 and 0xFFF when control is 1. The converter register keeps its value.
- R12: With override high, the output code equals the converter register. It returns to that value as soon as override is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_d | input | 8 | Processor data byte |
| wr_n | input | 1 | Write strobe, active low |
| cs_hi_n | input | 1 | High-byte select, active low |
| cs_lo_n | input | 1 | Low-byte select, active low |
| ld_n | input | 1 | Load converter register, active low |
| ovr_n | input | 1 | Output override, active low |
| ctl | input | 1 | Packing select, or forced level while overriding |
| dac_code | output | 12 | Code driven to the converter |
| in_word | output | 12 | Input holding register contents |
| dac_word | output | 12 | Converter register contents |

## Verification
A wrong field merge or a wrong packing choice shows on in_word within three cycles of the write. A transfer taken at the wrong time, or one that uses the old word instead of the merged one, shows on dac_word in that same window. A repeated action under a held write shows only if the bus data changes while write is still low, so the bench changes data and selects in the middle of a held strobe. Override faults show on dac_code two cycles after the pin moves, while dac_word is expected to stay fixed.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int CODE_W = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = CODE_W - BYTE_W;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LO   = 2'd1,
        ACT_HI   = 2'd2,
        ACT_XFER = 2'd3
    } act_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              wr_n;
        logic              cs_hi_n;
        logic              cs_lo_n;
        logic              ld_n;
        logic              ovr_n;
        logic              ctl;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    typedef struct packed {
        act_e              act;
        logic              load;
        logic              right;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    function automatic logic [CODE_W-1:0] merge_byte(
        input logic [CODE_W-1:0] cur,
        input logic [BYTE_W-1:0] b,
        input logic              is_hi,
        input logic              right
    );
        logic [CODE_W-1:0] w;
        w = cur;
        if (!right && is_hi)       w[CODE_W-1 -: BYTE_W] = b;
        else if (!right && !is_hi) w[NIB_W-1:0]          = b[BYTE_W-1 -: NIB_W];
        else if (right && is_hi)   w[CODE_W-1 -: NIB_W]  = b[NIB_W-1:0];
        else                       w[BYTE_W-1:0]         = b;
        return w;
    endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output cmd_t  cmd
);
    logic wr_prev;
    logic wr_fall;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b1;
        else     wr_prev <= pins.wr_n;
    end

    assign wr_fall = wr_prev & ~pins.wr_n;

    always_comb begin
        cmd.act   = ACT_NONE;
        cmd.load  = 1'b0;
        cmd.right = pins.ctl;
        cmd.data  = pins.data;
        if (wr_fall) begin
            unique case ({pins.cs_hi_n, pins.cs_lo_n})
                2'b10: begin cmd.act = ACT_LO; cmd.load = ~pins.ld_n; end
                2'b01: begin cmd.act = ACT_HI; cmd.load = ~pins.ld_n; end
                2'b11: begin
                    if (!pins.ld_n) begin
                        cmd.act  = ACT_XFER;
                        cmd.load = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    output logic [CODE_W-1:0] in_q,
    output logic [CODE_W-1:0] dac_q
);
    logic [CODE_W-1:0] in_next;

    always_comb begin
        unique case (cmd.act)
            ACT_LO:  in_next = merge_byte(in_q, cmd.data, 1'b0, cmd.right);
            ACT_HI:  in_next = merge_byte(in_q, cmd.data, 1'b1, cmd.right);
            default: in_next = in_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            in_q <= in_next;
            if (cmd.load) dac_q <= in_next;
        end
    end
endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] bus_d,
    input  logic              wr_n,
    input  logic              cs_hi_n,
    input  logic              cs_lo_n,
    input  logic              ld_n,
    input  logic              ovr_n,
    input  logic              ctl,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] in_word,
    output logic [CODE_W-1:0] dac_word
);
    localparam pins_t PINS_IDLE = '{data: '0, wr_n: 1'b1, cs_hi_n: 1'b1,
                                    cs_lo_n: 1'b1, ld_n: 1'b1, ovr_n: 1'b1, ctl: 1'b0};

    pins_t pins_raw;
    pins_t pins_s;
    cmd_t  cmd;
    logic  wr_s;
    logic  ovr_s;
    logic  ctl_s;

    assign pins_raw = '{data: bus_d, wr_n: wr_n, cs_hi_n: cs_hi_n,
                        cs_lo_n: cs_lo_n, ld_n: ld_n, ovr_n: ovr_n, ctl: ctl};

    dacif_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign wr_s  = pins_s.wr_n;
    assign ovr_s = pins_s.ovr_n;
    assign ctl_s = pins_s.ctl;

    dacif_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .pins (pins_s),
        .cmd  (cmd)
    );

    dacif_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .in_q  (in_word),
        .dac_q (dac_word)
    );

    always_comb begin
        if (ovr_s) dac_code = dac_word;
        else       dac_code = {CODE_W{ctl_s}};
    end
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
    import dacif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_s,
    input logic              ovr_s,
    input logic              ctl_s,
    input act_e              act,
    input logic              load,
    input logic [CODE_W-1:0] in_word,
    input logic [CODE_W-1:0] dac_word,
    input logic [CODE_W-1:0] dac_code
);
    AST_WR_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_s |=> ($stable(in_word) && $stable(dac_word))) else $error("AST_WR_HIGH_HOLD"); // R6

    AST_DAC_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dac_word)) else $error("AST_DAC_ONLY_ON_LOAD"); // R2

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_XFER) |=> (dac_word == $past(in_word) && $stable(in_word))) else $error("AST_XFER_COPY"); // R5

    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
        load |=> (dac_word == in_word)) else $error("AST_LOAD_MATCH"); // R4

    AST_OVR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!ovr_s && !ctl_s) |-> (dac_code == '0)) else $error("AST_OVR_ZERO"); // R11

    AST_OVR_ONES: assert property (@(posedge clk) disable iff (rst)
        (!ovr_s && ctl_s) |-> (dac_code == '1)) else $error("AST_OVR_ONES"); // R11

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        ovr_s |-> (dac_code == dac_word)) else $error("AST_PASS_THROUGH"); // R12

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_NONE) |=> (act == ACT_NONE)) else $error("AST_SINGLE_ACTION"); // R8
endmodule

bind dacif_top dacif_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_s     (wr_s),
    .ovr_s    (ovr_s),
    .ctl_s    (ctl_s),
    .act      (cmd.act),
    .load     (cmd.load),
    .in_word  (in_word),
    .dac_word (dac_word),
    .dac_code (dac_code)
);

// File: tb/dacif_top_tb.sv
module dacif_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_d = '0;
    logic        wr_n = 1'b1, cs_hi_n = 1'b1, cs_lo_n = 1'b1, ld_n = 1'b1;
    logic        ovr_n = 1'b1, ctl = 1'b0;
    logic [11:0] dac_code, in_word, dac_word;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [11:0] m_in = '0;
    logic [11:0] m_dac = '0;

    always #5 clk = ~clk;

    dacif_top u_dut (
        .clk(clk), .rst(rst), .bus_d(bus_d), .wr_n(wr_n), .cs_hi_n(cs_hi_n),
        .cs_lo_n(cs_lo_n), .ld_n(ld_n), .ovr_n(ovr_n), .ctl(ctl),
        .dac_code(dac_code), .in_word(in_word), .dac_word(dac_word)
    );

    task automatic check(input string req, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "in_word", in_word, m_in);
        check(req, "dac_word", dac_word, m_dac);
        check(req, "dac_code", dac_code, m_dac);
    endtask

    // Model of the packing rules, written from R9 and R10
    task automatic model_byte(input logic hi, input logic [7:0] b, input logic right, input logic load);
        int v;
        v = int'(m_in);
        if (!right && hi)       v = (v & 'h00F) | (int'(b) << 4);
        else if (!right && !hi) v = (v & 'hFF0) | (int'(b) >> 4);
        else if (right && hi)   v = (v & 'h0FF) | ((int'(b) & 'hF) << 8);
        else                    v = (v & 'hF00) | int'(b);
        m_in = 12'(v);
        if (load) m_dac = m_in;
    endtask

    task automatic strobe(input logic chi, input logic clo, input logic ld, input logic [7:0] d);
        @(negedge clk);
        bus_d = d; cs_hi_n = chi; cs_lo_n = clo; ld_n = ld;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_hi_n = 1'b1; cs_lo_n = 1'b1; ld_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1");

        // Sweep: both packings, both byte orders, load-with-byte and separate transfer
        for (int j = 0; j < 2; j++) begin
            ctl = j[0];
            for (int k = 0; k < 16; k++) begin
                logic [11:0] w;
                logic [7:0]  hb, lb;
                logic [3:0]  junk;
                w    = 12'((k * 'h5A3 + 'h0F1 + j * 'h3C) & 'hFFF);
                junk = ~4'(k);
                if (!ctl) begin hb = w[11:4]; lb = {w[3:0], junk}; end     // R9
                else      begin hb = {junk, w[11:8]}; lb = w[7:0]; end     // R10
                if (k[0]) begin
                    strobe(1'b0, 1'b1, 1'b1, hb); model_byte(1'b1, hb, ctl, 1'b0);
                    check_all("R3");
                    strobe(1'b1, 1'b0, k[1] ? 1'b0 : 1'b1, lb); model_byte(1'b0, lb, ctl, k[1]);
                    check_all(k[1] ? "R4" : "R2");
                end else begin
                    strobe(1'b1, 1'b0, 1'b1, lb); model_byte(1'b0, lb, ctl, 1'b0);
                    check_all("R2");
                    strobe(1'b0, 1'b1, k[1] ? 1'b0 : 1'b1, hb); model_byte(1'b1, hb, ctl, k[1]);
                    check_all(k[1] ? "R4" : "R3");
                end
                check(ctl ? "R10" : "R9", "assembled word", in_word, w);
                if (!k[1]) begin
                    strobe(1'b1, 1'b1, 1'b0, 8'hA5);
                    m_dac = m_in;
                    check_all("R5");
                end
            end
        end

        // R6: strobe activity with write high changes nothing
        ctl = 1'b1;
        @(negedge clk);
        bus_d = 8'h3C; cs_lo_n = 1'b0; ld_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_lo_n = 1'b1; cs_hi_n = 1'b0; bus_d = 8'hC3;
        repeat (4) @(negedge clk);
        cs_hi_n = 1'b1;
        repeat (4) @(negedge clk);
        ld_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R6");

        // R7: both selects low takes no action, even with load low
        strobe(1'b0, 1'b0, 1'b0, 8'h99);
        check_all("R7");

        // R8: write held low acts once; later changes ignored; latency 3 cycles
        @(negedge clk);
        bus_d = 8'h5E; cs_lo_n = 1'b0; ld_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        model_byte(1'b0, 8'h5E, 1'b1, 1'b0);
        check("R8", "in_word latency", in_word, m_in);
        bus_d = 8'hE7; cs_lo_n = 1'b1; cs_hi_n = 1'b0; ld_n = 1'b0;
        repeat (5) @(negedge clk);
        check_all("R8");
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_hi_n = 1'b1; ld_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R8");

        // Load a known value into the converter register, then override
        strobe(1'b0, 1'b1, 1'b1, 8'h0A);
        model_byte(1'b1, 8'h0A, 1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0, 8'h6B);
        model_byte(1'b0, 8'h6B, 1'b1, 1'b1);
        check_all("R4");

        @(negedge clk); ovr_n = 1'b0; ctl = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "forced zero", dac_code, 12'h000);
        check("R11", "dac_word kept", dac_word, m_dac);
        ctl = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "forced ones", dac_code, 12'hFFF);
        check("R11", "dac_word kept", dac_word, m_dac);
        ovr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12", "release", dac_code, m_dac);
        check("R12", "dac_word", dac_word, 12'hA6B);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule